// File: doc/BRIEF.md
# Equalizer Calibration Sweep Controller

This block calibrates nine receive-equalizer settings, each held as a 7-bit code. It works through the settings one at a time. For each setting it presents a series of candidate codes to the equalizer and reads back a quality metric for every candidate. When a setting's series is finished, the controller keeps the code that produced the best metric. The settings are, by index: low-frequency gain (0), high-frequency gain (1), AC boost (2), pulse-shaping DFE cut-off (3), pulse-shaping DFE gain (4), and the decision-feedback taps N-1 to N-4 (5 to 8).

A calibration begins with a start pulse while the enable input is high. It has two phases. The coarse phase runs first, repeated a programmed number of times with its own step size. The fine phase follows, with its own step size and its own repeat count. A run mask chooses which settings take part. During each measurement the controller raises a request and holds the candidate steady until the metric arrives with a valid strobe. At the end it pulses done. Lowering enable abandons the calibration at once.

Top module: `eqcal_ctrl`

## Requirements
- R1: After reset every code output is 0, and busy, done and meas_req are low.
- R2: A cal_start pulse begins a calibration only while cfg_enable is high. A cal_start pulse while cfg_enable is low leaves busy low and starts no measurement.
- R3: Bit i of cfg_run_mask (1 means sweep) selects setting i. Setting i is bits [7i+6:7i] of eq_code. A setting whose mask bit is 0 keeps its code through the whole run.
- R4: Within one sweep of a setting, the candidates are 0, s, 2s, and so on, in that order. The last candidate is 127: a step that would go past 127 is clamped to 127. A step field of 0 behaves as a step of 1.
- R5: Each candidate stays on that setting's eq_code field, with meas_req high, until metric_valid arrives. A metric_valid pulse while meas_req is low has no effect.
- R6: After a sweep, the setting's code becomes the candidate whose metric was highest, compared as unsigned values. When candidates tie, the lowest of the tied codes wins.
- R7: The coarse pass over all masked settings runs cfg_coarse_iters times with cfg_coarse_step. The fine pass then runs cfg_fine_iters times with cfg_fine_step. A count of 0 skips that phase. Each pass makes one measurement per candidate of R4 for every masked setting.
- R8: done is high for exactly one cycle after the last measurement, and busy is low in that cycle. busy is high for the whole of every calibration that measures.
- R9: If cfg_enable goes low during a calibration, busy and meas_req are low in the next cycle and done does not pulse. Every code output then shows its last committed value; the candidate in flight is discarded.
- R10: With a zero run mask, or with both iteration counts at 0, a start produces done without any measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Calibration enable, active high |
| cal_start | input | 1 | One-cycle request to begin a calibration |
| cfg_run_mask | input | 9 | Per-setting sweep select |
| cfg_coarse_step | input | 5 | Coarse-phase code step |
| cfg_fine_step | input | 5 | Fine-phase code step |
| cfg_coarse_iters | input | 7 | Number of coarse passes |
| cfg_fine_iters | input | 7 | Number of fine passes |
| metric_valid | input | 1 | Strobe marking metric as the result for the current candidate |
| metric | input | 16 | Quality metric from the receiver |
| eq_code | output | 63 | Nine 7-bit equalizer codes, setting i in bits [7i+6:7i] |
| meas_req | output | 1 | A candidate is applied and a metric is awaited |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle pulse at the end of a calibration |

## Verification
Two situations are the hardest to reach. The first is a tie between candidates of equal metric. The bench's equalizer model builds it by giving each setting two peaks of equal height, 40 codes apart, and running a fine pass with step 1 so that both peaks are measured. The second is an abort in the middle of a sweep, before any setting has been committed. The bench reaches it by counting the metric answers it has returned and dropping enable after the fiftieth. At that point it checks that the codes still hold their values from before the run. The model scores each setting on its own, so the bench can predict every final code from the candidate series alone. The model also answers after varying delays, which tests that each candidate is held until its metric arrives.

// File: rtl/eqcal_pkg.sv
package eqcal_pkg;
  localparam int EQ_NVAR     = 9;
  localparam int EQ_CODE_W   = 7;
  localparam int EQ_STEP_W   = 5;
  localparam int EQ_ITER_W   = 7;
  localparam int EQ_METRIC_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_MEAS = 2'd2,
    ST_DONE = 2'd3
  } eq_state_t;
endpackage

// File: rtl/eqcal_stepper.sv
module eqcal_stepper #(
  parameter int CODE_W = 7,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic [CODE_W-1:0] cand,
  output logic              at_max
);
  localparam int SUM_W = ((CODE_W > STEP_W) ? CODE_W : STEP_W) + 1;
  localparam logic [SUM_W-1:0] CODE_MAX = SUM_W'((1 << CODE_W) - 1);

  logic [STEP_W-1:0] step_eff;
  logic [SUM_W-1:0]  sum;
  logic [CODE_W-1:0] nxt;
  logic [CODE_W-1:0] cand_q, cand_d;
  logic              cand_en;

  // A zero step would never reach the top code, so it is treated as one.
  assign step_eff = (step == '0) ? STEP_W'(1) : step;
  assign sum      = SUM_W'(cand_q) + SUM_W'(step_eff);
  assign nxt      = (sum > CODE_MAX) ? CODE_MAX[CODE_W-1:0] : sum[CODE_W-1:0];

  assign cand_en = clr | adv;

  always_comb begin
    cand_d = cand_q;
    if (clr)      cand_d = '0;
    else if (adv) cand_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cand_q <= '0;
    else if (cand_en) cand_q <= cand_d;
  end

  assign cand   = cand_q;
  assign at_max = (SUM_W'(cand_q) == CODE_MAX);
endmodule

// File: rtl/eqcal_best.sv
module eqcal_best #(
  parameter int CODE_W   = 7,
  parameter int METRIC_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                smp,
  input  logic [METRIC_W-1:0] metric,
  input  logic [CODE_W-1:0]   code,
  output logic [CODE_W-1:0]   win_code
);
  logic                have_q;
  logic [METRIC_W-1:0] best_m_q;
  logic [CODE_W-1:0]   best_c_q;
  logic                take;
  logic                upd_en;

  // Strictly greater: with ascending candidates, ties stay with the lower code.
  assign take     = smp && (!have_q || (metric > best_m_q));
  assign win_code = take ? code : best_c_q;
  assign upd_en   = clr | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q   <= 1'b0;
      best_m_q <= '0;
      best_c_q <= '0;
    end else if (upd_en) begin
      if (clr) begin
        have_q   <= 1'b0;
        best_m_q <= '0;
        best_c_q <= '0;
      end else begin
        have_q   <= 1'b1;
        best_m_q <= metric;
        best_c_q <= code;
      end
    end
  end
endmodule

// File: rtl/eqcal_fsm.sv
module eqcal_fsm
  import eqcal_pkg::*;
#(
  parameter int NVAR   = 9,
  parameter int ITER_W = 7,
  parameter int VIDX_W = $clog2(NVAR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic [NVAR-1:0]   mask,
  input  logic [ITER_W-1:0] coarse_iters,
  input  logic [ITER_W-1:0] fine_iters,
  input  logic              metric_valid,
  input  logic              at_max,
  output logic [VIDX_W-1:0] var_idx,
  output logic              fine_phase,
  output logic              sweep_init,
  output logic              step_adv,
  output logic              sample,
  output logic              commit,
  output logic              busy,
  output logic              meas_req,
  output logic              done
);
  eq_state_t         state_q, state_d;
  logic [VIDX_W-1:0] var_q, var_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic              fine_q, fine_d;
  logic [ITER_W-1:0] cur_lim;
  logic              last_iter;

  assign cur_lim   = fine_q ? fine_iters : coarse_iters;
  assign last_iter = ((ITER_W+1)'(iter_q) + (ITER_W+1)'(1)) >= (ITER_W+1)'(cur_lim);

  always_comb begin
    state_d    = state_q;
    var_d      = var_q;
    iter_d     = iter_q;
    fine_d     = fine_q;
    sweep_init = 1'b0;
    step_adv   = 1'b0;
    sample     = 1'b0;
    commit     = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            var_d  = '0;
            iter_d = '0;
            if (coarse_iters != '0) begin
              fine_d  = 1'b0;
              state_d = ST_SEL;
            end else if (fine_iters != '0) begin
              fine_d  = 1'b1;
              state_d = ST_SEL;
            end else begin
              state_d = ST_DONE;
            end
          end
        end
        ST_SEL: begin
          if (var_q == VIDX_W'(NVAR)) begin
            var_d = '0;
            if (last_iter) begin
              if (!fine_q && (fine_iters != '0)) begin
                fine_d = 1'b1;
                iter_d = '0;
              end else begin
                state_d = ST_DONE;
              end
            end else begin
              iter_d = iter_q + 1'b1;
            end
          end else if (mask[var_q]) begin
            sweep_init = 1'b1;
            state_d    = ST_MEAS;
          end else begin
            var_d = var_q + 1'b1;
          end
        end
        ST_MEAS: begin
          if (metric_valid) begin
            sample = 1'b1;
            if (at_max) begin
              commit  = 1'b1;
              var_d   = var_q + 1'b1;
              state_d = ST_SEL;
            end else begin
              step_adv = 1'b1;
            end
          end
        end
        ST_DONE: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      var_q   <= '0;
      iter_q  <= '0;
      fine_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      var_q   <= var_d;
      iter_q  <= iter_d;
      fine_q  <= fine_d;
    end
  end

  assign var_idx    = var_q;
  assign fine_phase = fine_q;
  assign busy       = (state_q == ST_SEL) || (state_q == ST_MEAS);
  assign meas_req   = (state_q == ST_MEAS);
  assign done       = (state_q == ST_DONE);
endmodule

// File: rtl/eqcal_ctrl.sv
module eqcal_ctrl
  import eqcal_pkg::*;
#(
  parameter int NVAR     = EQ_NVAR,
  parameter int CODE_W   = EQ_CODE_W,
  parameter int STEP_W   = EQ_STEP_W,
  parameter int ITER_W   = EQ_ITER_W,
  parameter int METRIC_W = EQ_METRIC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_enable,
  input  logic                   cal_start,
  input  logic [NVAR-1:0]        cfg_run_mask,
  input  logic [STEP_W-1:0]      cfg_coarse_step,
  input  logic [STEP_W-1:0]      cfg_fine_step,
  input  logic [ITER_W-1:0]      cfg_coarse_iters,
  input  logic [ITER_W-1:0]      cfg_fine_iters,
  input  logic                   metric_valid,
  input  logic [METRIC_W-1:0]    metric,
  output logic [NVAR*CODE_W-1:0] eq_code,
  output logic                   meas_req,
  output logic                   busy,
  output logic                   done
);
  localparam int VIDX_W = $clog2(NVAR + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [VIDX_W-1:0] var_idx;
  logic              fine_phase;
  logic              sweep_init, step_adv, sample, commit;
  logic [CODE_W-1:0] cand, win_code;
  logic              at_max;
  logic [STEP_W-1:0] cur_step;

  // Reset asserts at once and is released two clock edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign cur_step = fine_phase ? cfg_fine_step : cfg_coarse_step;

  eqcal_fsm #(.NVAR(NVAR), .ITER_W(ITER_W), .VIDX_W(VIDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .enable(cfg_enable), .start(cal_start),
    .mask(cfg_run_mask), .coarse_iters(cfg_coarse_iters), .fine_iters(cfg_fine_iters),
    .metric_valid(metric_valid), .at_max(at_max), .var_idx(var_idx),
    .fine_phase(fine_phase), .sweep_init(sweep_init), .step_adv(step_adv),
    .sample(sample), .commit(commit), .busy(busy), .meas_req(meas_req), .done(done)
  );

  eqcal_stepper #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_step (
    .clk(clk), .rst_n(rst_n_s), .clr(sweep_init), .adv(step_adv),
    .step(cur_step), .cand(cand), .at_max(at_max)
  );

  eqcal_best #(.CODE_W(CODE_W), .METRIC_W(METRIC_W)) u_best (
    .clk(clk), .rst_n(rst_n_s), .clr(sweep_init), .smp(sample),
    .metric(metric), .code(cand), .win_code(win_code)
  );

  // Committed codes; the in-flight candidate only reaches the output mux.
  for (genvar gi = 0; gi < NVAR; gi++) begin : g_var
    logic [CODE_W-1:0] code_q;
    logic              code_we;
    logic              is_cur;

    assign is_cur  = (var_idx == VIDX_W'(gi));
    assign code_we = commit && is_cur;

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)     code_q <= '0;
      else if (code_we) code_q <= win_code;
    end

    assign eq_code[gi*CODE_W +: CODE_W] = (meas_req && is_cur) ? cand : code_q;
  end
endmodule

// File: rtl/eqcal_ctrl_chk.sv
module eqcal_ctrl_chk #(
  parameter int NVAR   = 9,
  parameter int CODE_W = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_enable,
  input logic                   metric_valid,
  input logic [NVAR*CODE_W-1:0] eq_code,
  input logic                   meas_req,
  input logic                   busy,
  input logic                   done
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_req_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |-> busy);

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && !metric_valid && cfg_enable) |=> (meas_req && $stable(eq_code)));

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!busy && !meas_req));

  assert_idle_codes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(eq_code));
endmodule

bind eqcal_ctrl eqcal_ctrl_chk #(.NVAR(NVAR), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .metric_valid(metric_valid),
  .eq_code(eq_code), .meas_req(meas_req), .busy(busy), .done(done)
);

// File: tb/eqcal_ctrl_bench.sv
`timescale 1ns/1ps
module eqcal_ctrl_bench;
  localparam int NV = 9;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_enable, cal_start;
  logic [NV-1:0] cfg_run_mask;
  logic [4:0]    cfg_coarse_step, cfg_fine_step;
  logic [6:0]    cfg_coarse_iters, cfg_fine_iters;
  logic          metric_valid;
  logic [15:0]   metric;
  logic [NV*CW-1:0] eq_code;
  logic          meas_req, busy, done;

  eqcal_ctrl u_eqcal_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cal_start(cal_start),
    .cfg_run_mask(cfg_run_mask), .cfg_coarse_step(cfg_coarse_step),
    .cfg_fine_step(cfg_fine_step), .cfg_coarse_iters(cfg_coarse_iters),
    .cfg_fine_iters(cfg_fine_iters), .metric_valid(metric_valid), .metric(metric),
    .eq_code(eq_code), .meas_req(meas_req), .busy(busy), .done(done)
  );

  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int meas_cnt = 0;
  int done_cnt = 0;
  int model_mode = 1;
  bit resp_on = 1'b1;
  bit stray_pulse = 1'b0;
  int log_var = 0;
  int log_base = 0;
  int cand_log [256];
  int exp_c [NV];
  int pre_c [NV];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int get_code(input int v);
    return int'(eq_code[v*CW +: CW]);
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int peak1(input int v);
    return (v * 29 + 13) % 128;
  endfunction

  function automatic int peak2(input int v);
    int p = peak1(v);
    return (p + 40 <= 127) ? p + 40 : p - 40;
  endfunction

  function automatic int score(input int v, input int c);
    int d1 = absd(c, peak1(v));
    int d2 = absd(c, peak2(v));
    if (model_mode == 0) return 100;
    if (model_mode == 1) return 200 - d1;
    return 200 - ((d1 < d2) ? d1 : d2);
  endfunction

  function automatic int calc_metric();
    int s = 0;
    for (int v = 0; v < NV; v++) s += score(v, get_code(v));
    return s;
  endfunction

  function automatic int next_cand(input int c, input int s);
    int se = (s == 0) ? 1 : s;
    return (c + se > 127) ? 127 : c + se;
  endfunction

  function automatic int n_cands(input int s);
    int c = 0;
    int n = 0;
    while (1) begin
      n++;
      if (c == 127) break;
      c = next_cand(c, s);
    end
    return n;
  endfunction

  function automatic int best_code(input int v, input int s);
    int c = 0;
    int bm = -1;
    int bc = 0;
    while (1) begin
      if (score(v, c) > bm) begin
        bm = score(v, c);
        bc = c;
      end
      if (c == 127) break;
      c = next_cand(c, s);
    end
    return bc;
  endfunction

  // Equalizer and metric model: answers each request after 0..2 extra cycles.
  initial begin
    metric_valid = 1'b0;
    metric = '0;
    forever begin
      @(negedge clk);
      metric_valid = 1'b0;
      if (stray_pulse) begin
        metric = 16'hFFFF;
        metric_valid = 1'b1;
        stray_pulse = 1'b0;
      end else if (meas_req && resp_on) begin
        repeat (meas_cnt % 3) @(negedge clk);
        if (meas_req) begin
          metric = 16'(calc_metric());
          if (meas_cnt - log_base >= 0 && meas_cnt - log_base < 256)
            cand_log[meas_cnt - log_base] = get_code(log_var);
          meas_cnt++;
          metric_valid = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) if (done) done_cnt++;

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic set_cfg(input int mask, input int cs, input int fs,
                         input int ci, input int fi);
    cfg_run_mask     = NV'(mask);
    cfg_coarse_step  = 5'(cs);
    cfg_fine_step    = 5'(fs);
    cfg_coarse_iters = 7'(ci);
    cfg_fine_iters   = 7'(fi);
  endtask

  // Starts a run, waits for done, checks done width, busy and codes (R6, R7, R8).
  task automatic run_and_check(input string req, input int mask, input int cs,
                               input int fs, input int ci, input int fi);
    int m0, d0, t, exp_meas, pc;
    bit busy_seen;
    set_cfg(mask, cs, fs, ci, fi);
    for (int v = 0; v < NV; v++) begin
      pre_c[v] = get_code(v);
      if (mask[v] && fi > 0)      exp_c[v] = best_code(v, fs);
      else if (mask[v] && ci > 0) exp_c[v] = best_code(v, cs);
      else                        exp_c[v] = pre_c[v];
    end
    pc = $countones(NV'(mask));
    exp_meas = pc * (ci * n_cands(cs) + fi * n_cands(fs));
    m0 = meas_cnt;
    d0 = done_cnt;
    @(negedge clk) cal_start = 1'b1;
    @(negedge clk) cal_start = 1'b0;
    busy_seen = busy;
    t = 0;
    while (!done && t < 150000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, req, "done reached", int'(done), 1);
    chk(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
    if (exp_meas > 0) chk(busy_seen, "R8", "busy after start", int'(busy_seen), 1);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", int'(done), 0);
    chk(done_cnt - d0 == 1, "R8", "done pulse count", done_cnt - d0, 1);
    chk(meas_cnt - m0 == exp_meas, "R7", "measurement count", meas_cnt - m0, exp_meas);
    for (int v = 0; v < NV; v++)
      chk(get_code(v) == exp_c[v], req, $sformatf("code of setting %0d", v),
          get_code(v), exp_c[v]);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(meas_req == 1'b0, "R1", "meas_req after reset", int'(meas_req), 0);
    for (int v = 0; v < NV; v++)
      chk(get_code(v) == 0, "R1", $sformatf("reset code %0d", v), get_code(v), 0);
  endtask

  task automatic t_start_disabled();
    int m0 = meas_cnt;
    cfg_enable = 1'b0;
    @(negedge clk) cal_start = 1'b1;
    @(negedge clk) cal_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2", "start ignored while disabled", int'(busy), 0);
    chk(meas_cnt == m0, "R2", "no measurement while disabled", meas_cnt - m0, 0);
    cfg_enable = 1'b1;
  endtask

  task automatic t_stray_valid();
    for (int v = 0; v < NV; v++) pre_c[v] = get_code(v);
    stray_pulse = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R5", "stray valid leaves idle", int'(busy), 0);
    for (int v = 0; v < NV; v++)
      chk(get_code(v) == pre_c[v], "R5", $sformatf("stray valid code %0d", v),
          get_code(v), pre_c[v]);
  endtask

  task automatic t_saturate();
    int n;
    int c = 0;
    log_var  = 3;
    log_base = meas_cnt;
    run_and_check("R4", 9'h008, 20, 1, 1, 0);
    n = n_cands(20);
    for (int k = 0; k < n; k++) begin
      chk(cand_log[k] == c, "R4", $sformatf("candidate %0d", k), cand_log[k], c);
      c = next_cand(c, 20);
    end
    chk(cand_log[n-1] == 127, "R4", "last candidate clamped", cand_log[n-1], 127);
  endtask

  task automatic t_abort();
    int m0, d0;
    model_mode = 1;
    set_cfg(9'h1FD, 2, 1, 2, 4);
    for (int v = 0; v < NV; v++) pre_c[v] = get_code(v);
    m0 = meas_cnt;
    d0 = done_cnt;
    @(negedge clk) cal_start = 1'b1;
    @(negedge clk) cal_start = 1'b0;
    while (meas_cnt - m0 < 50) @(negedge clk);
    cfg_enable = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after abort", int'(busy), 0);
    chk(meas_req == 1'b0, "R9", "meas_req after abort", int'(meas_req), 0);
    repeat (5) @(negedge clk);
    chk(done_cnt == d0, "R9", "no done after abort", done_cnt - d0, 0);
    for (int v = 0; v < NV; v++)
      chk(get_code(v) == pre_c[v], "R9", $sformatf("abort code %0d", v),
          get_code(v), pre_c[v]);
    cfg_enable = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_enable = 1'b1;
    cal_start = 1'b0;
    set_cfg(9'h1FD, 2, 1, 2, 4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_start_disabled();
    model_mode = 1;
    run_and_check("R6", 9'h1FD, 2, 1, 2, 4);
    chk(get_code(1) == 0, "R3", "default mask skips setting 1", get_code(1), 0);
    t_stray_valid();
    run_and_check("R3", 9'h109, 5, 1, 1, 0);
    t_saturate();
    run_and_check("R4", 9'h040, 0, 1, 1, 0);
    model_mode = 2;
    run_and_check("R6", 9'h1FF, 9, 1, 1, 1);
    model_mode = 0;
    run_and_check("R6", 9'h0A0, 3, 3, 0, 1);
    model_mode = 1;
    run_and_check("R10", 9'h000, 2, 1, 2, 4);
    run_and_check("R10", 9'h1FF, 2, 1, 0, 0);
    run_and_check("R7", 9'h011, 7, 3, 0, 2);
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule